// File: doc/BRIEF.md
# Event Flag Capture and Poll/Wait Unit

This unit keeps sixteen sticky event flags for a single processor core. Each flag latches a one-cycle pulse from its source and stays set until the core consumes it. The sources are the interrupt, three counter targets, four selectable events, the pin pattern, the FIFO wrap, four streamer conditions, the attention strobe and the empty result queue. The core reads a flag through the query port. The query port serves both a poll and a jump that tests a flag, and the read clears the flag. The core can also block on a flag through the wait port. A wait may carry a cycle-count timeout and reports whether it ended by the event or by that timeout.

Most flags can also be dropped by a dedicated clear line. Each line is driven by the command that owns that event, such as re-arming a counter target or reselecting a selectable event. When a set pulse and any clear meet in the same cycle, the set is kept, so no event is lost.

Top module: `evt_flag_unit`

## Requirements
- R1: After reset, all flags read 0, and `poll_valid`, `wait_busy` and `wait_done` are low.
- R2: Event IDs are fixed: 0 interrupt, 1-3 counter targets, 4-7 selectable events, 8 pattern, 9 FIFO wrap, 10 streamer ready, 11 streamer empty, 12 streamer rollover, 13 streamer table end, 14 attention, 15 result-queue empty. For IDs 1-13 and 15, a pulse on `src_pulse[id]` sets the flag, and the flag can be read from the next cycle on.
- R3: A query raised with `poll_req` and `poll_id` in cycle n gives `poll_valid` high in cycle n+1. In that cycle `poll_c` and `poll_z` both equal the flag as it stood in cycle n, and the flag is cleared.
- R4: The interrupt flag (ID 0) is set by `irq_pulse` only while `irq_debug` is low. `src_pulse[0]` has no effect.
- R5: The attention flag (ID 14) is set when `atn_strobe` is high and `atn_targets[CORE_ID]` is 1. Strobes that target only other cores have no effect, and so does `src_pulse[14]`.
- R6: `clr_cmd[id]` clears the flag for IDs 1-12 only. `clr_cmd` bits 0, 13, 14 and 15 have no effect.
- R7: A set pulse in the same cycle as a dedicated clear or a query of that flag leaves the flag set.
- R8: A wait starts with `wait_start` and `wait_id` in cycle 0. `wait_busy` is high from cycle 1 until the wait ends. If the flag is set in cycle k≥1, `wait_done` pulses in cycle k+1 with `wait_timed_out` low, and the flag is cleared. A wait on a flag that is already set therefore ends in cycle 2.
- R9: A wait with `wait_use_tmo` low never times out. It ends only when the flag is set.
- R10: With `wait_use_tmo` high and `wait_tmo`=T (T=0 acts as 1), if the flag has not been set by cycle T, `wait_done` pulses in cycle T+1 with `wait_timed_out` high, and the flag is left unchanged.
- R11: If the flag is first seen set in cycle T itself, the event wins: the wait ends in cycle T+1 with `wait_timed_out` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pulse | input | 16 | Per-ID set pulses (bits 0 and 14 unused) |
| irq_pulse | input | 1 | Interrupt taken |
| irq_debug | input | 1 | The interrupt is a debug interrupt |
| atn_strobe | input | 1 | Attention strobe from another core |
| atn_targets | input | NUM_CORES | Target core mask of the strobe |
| clr_cmd | input | 16 | Dedicated per-ID clear |
| poll_req | input | 1 | Query (poll or flag jump) request |
| poll_id | input | 4 | Queried event ID |
| poll_valid | output | 1 | Query result valid |
| poll_c | output | 1 | Query result, C copy |
| poll_z | output | 1 | Query result, Z copy |
| wait_start | input | 1 | Begin a wait |
| wait_id | input | 4 | Awaited event ID |
| wait_use_tmo | input | 1 | Enable the timeout |
| wait_tmo | input | TMO_W | Timeout in cycles |
| wait_busy | output | 1 | Core stalled in a wait |
| wait_done | output | 1 | Wait finished (one-cycle pulse) |
| wait_timed_out | output | 1 | Last wait ended by timeout |

## Verification
The bench builds the unit with CORE_ID=3 and TMO_W=8. A non-zero core index checks that the attention match uses the right bit of the target mask, and not simply bit 0. An 8-bit timeout keeps waits short, so the bench can reach every timeout boundary cycle by cycle: zero, expiry with no event, an event first seen on the expiry cycle, and an event one cycle too late.

// File: rtl/evt_pkg.sv
package evt_pkg;

    localparam int NUM_EVT  = 16;
    localparam int EVT_ID_W = 4;

    typedef enum logic [EVT_ID_W-1:0] {
        EV_IRQ        = 4'd0,
        EV_TGT1       = 4'd1,
        EV_TGT2       = 4'd2,
        EV_TGT3       = 4'd3,
        EV_SEL1       = 4'd4,
        EV_SEL2       = 4'd5,
        EV_SEL3       = 4'd6,
        EV_SEL4       = 4'd7,
        EV_PIN_PAT    = 4'd8,
        EV_FIFO_WRAP  = 4'd9,
        EV_STR_READY  = 4'd10,
        EV_STR_EMPTY  = 4'd11,
        EV_STR_ROLL   = 4'd12,
        EV_STR_TBLEND = 4'd13,
        EV_ATTN       = 4'd14,
        EV_QEMPTY     = 4'd15
    } evt_id_e;

    typedef logic [NUM_EVT-1:0] evt_vec_t;

    // Sources taken straight from src_pulse (interrupt and attention come in separately).
    localparam evt_vec_t SRC_DIRECT_MASK = ~((evt_vec_t'(1) << EV_IRQ) | (evt_vec_t'(1) << EV_ATTN));

    // Flags that own a dedicated clearing command: IDs 1..12.
    localparam evt_vec_t CLR_OWNED_MASK = evt_vec_t'(16'h1FFE);

    typedef enum logic {
        WS_IDLE = 1'b0,
        WS_WAIT = 1'b1
    } wait_state_e;

    function automatic evt_vec_t id_onehot(input logic [EVT_ID_W-1:0] id);
        return evt_vec_t'(1) << id;
    endfunction

endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank
    import evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  evt_vec_t set_vec,
    input  evt_vec_t clr_vec,
    output evt_vec_t flags_q
);

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flags_q[i] <= 1'b0;
            end else if (set_vec[i]) begin
                flags_q[i] <= 1'b1;
            end else if (clr_vec[i]) begin
                flags_q[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/evt_poll_port.sv
module evt_poll_port
    import evt_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req,
    input  logic [EVT_ID_W-1:0] id,
    input  evt_vec_t            flags,
    output logic                valid,
    output logic                result,
    output evt_vec_t            clr_vec
);

    always_comb begin
        clr_vec = req ? id_onehot(id) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid  <= 1'b0;
            result <= 1'b0;
        end else begin
            valid  <= req;
            result <= req ? flags[id] : 1'b0;
        end
    end

endmodule

// File: rtl/evt_wait_ctrl.sv
module evt_wait_ctrl
    import evt_pkg::*;
#(
    parameter int TMO_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [EVT_ID_W-1:0] id,
    input  logic                use_tmo,
    input  logic [TMO_W-1:0]    tmo,
    input  evt_vec_t            flags,
    output logic                busy,
    output logic                done,
    output logic                timed_out,
    output evt_vec_t            clr_vec
);

    localparam logic [TMO_W-1:0] ONE = TMO_W'(1);

    wait_state_e         state_q;
    logic [EVT_ID_W-1:0] wid_q;
    logic                use_q;
    logic [TMO_W-1:0]    cnt_q;
    logic                hit;
    logic                expire;

    always_comb begin
        hit     = (state_q == WS_WAIT) && flags[wid_q];
        expire  = (state_q == WS_WAIT) && !hit && use_q && (cnt_q <= ONE);
        clr_vec = hit ? id_onehot(wid_q) : '0;
        busy    = (state_q == WS_WAIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= WS_IDLE;
            wid_q     <= '0;
            use_q     <= 1'b0;
            cnt_q     <= '0;
            done      <= 1'b0;
            timed_out <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                WS_IDLE: begin
                    if (start) begin
                        state_q <= WS_WAIT;
                        wid_q   <= id;
                        use_q   <= use_tmo;
                        cnt_q   <= tmo;
                    end
                end
                WS_WAIT: begin
                    if (hit) begin
                        state_q   <= WS_IDLE;
                        done      <= 1'b1;
                        timed_out <= 1'b0;
                    end else if (expire) begin
                        state_q   <= WS_IDLE;
                        done      <= 1'b1;
                        timed_out <= 1'b1;
                    end else if (cnt_q != '0) begin
                        cnt_q <= cnt_q - ONE;
                    end
                end
                default: state_q <= WS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/evt_flag_unit.sv
module evt_flag_unit
    import evt_pkg::*;
#(
    parameter int CORE_ID   = 0,
    parameter int NUM_CORES = 8,
    parameter int TMO_W     = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_EVT-1:0]   src_pulse,
    input  logic                 irq_pulse,
    input  logic                 irq_debug,
    input  logic                 atn_strobe,
    input  logic [NUM_CORES-1:0] atn_targets,
    input  logic [NUM_EVT-1:0]   clr_cmd,
    input  logic                 poll_req,
    input  logic [EVT_ID_W-1:0]  poll_id,
    output logic                 poll_valid,
    output logic                 poll_c,
    output logic                 poll_z,
    input  logic                 wait_start,
    input  logic [EVT_ID_W-1:0]  wait_id,
    input  logic                 wait_use_tmo,
    input  logic [TMO_W-1:0]     wait_tmo,
    output logic                 wait_busy,
    output logic                 wait_done,
    output logic                 wait_timed_out
);

    localparam logic [NUM_CORES-1:0] SELF_MASK = NUM_CORES'(1) << CORE_ID;

    evt_vec_t set_vec;
    evt_vec_t clr_vec;
    evt_vec_t flags_q;
    evt_vec_t poll_clr;
    evt_vec_t wait_clr;
    logic     atn_hit;
    logic     poll_res;

    always_comb begin
        atn_hit = atn_strobe && |(atn_targets & SELF_MASK);
        set_vec = src_pulse & SRC_DIRECT_MASK;
        set_vec[EV_IRQ]  = irq_pulse && !irq_debug;
        set_vec[EV_ATTN] = atn_hit;
        clr_vec = (clr_cmd & CLR_OWNED_MASK) | poll_clr | wait_clr;
    end

    evt_flag_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags_q (flags_q)
    );

    evt_poll_port u_poll (
        .clk     (clk),
        .rst     (rst),
        .req     (poll_req),
        .id      (poll_id),
        .flags   (flags_q),
        .valid   (poll_valid),
        .result  (poll_res),
        .clr_vec (poll_clr)
    );

    always_comb begin
        poll_c = poll_res;
        poll_z = poll_res;
    end

    evt_wait_ctrl #(.TMO_W(TMO_W)) u_wait (
        .clk       (clk),
        .rst       (rst),
        .start     (wait_start),
        .id        (wait_id),
        .use_tmo   (wait_use_tmo),
        .tmo       (wait_tmo),
        .flags     (flags_q),
        .busy      (wait_busy),
        .done      (wait_done),
        .timed_out (wait_timed_out),
        .clr_vec   (wait_clr)
    );

endmodule

// File: rtl/evt_flag_unit_chk.sv
module evt_flag_unit_chk
    import evt_pkg::*;
#(
    parameter int CORE_ID   = 0,
    parameter int NUM_CORES = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 poll_req,
    input logic                 poll_valid,
    input logic                 poll_c,
    input logic                 poll_z,
    input logic                 wait_start,
    input logic                 wait_busy,
    input logic                 wait_done,
    input logic                 atn_strobe,
    input logic [NUM_CORES-1:0] atn_targets,
    input evt_vec_t             set_vec,
    input evt_vec_t             flags_q
);

    AST_POLL_LATENCY: assert property (@(posedge clk) disable iff (rst)
        poll_req |=> poll_valid); // R3

    AST_POLL_CZ_MATCH: assert property (@(posedge clk) disable iff (rst)
        poll_valid |-> (poll_c == poll_z)); // R3

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((flags_q & $past(set_vec)) == $past(set_vec))); // R7

    AST_ATN_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (atn_strobe && atn_targets[CORE_ID]) |=> flags_q[EV_ATTN]); // R5

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        wait_done |-> !wait_busy); // R8

    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        (wait_start && !wait_busy) |=> wait_busy); // R8

endmodule

bind evt_flag_unit evt_flag_unit_chk #(
    .CORE_ID   (CORE_ID),
    .NUM_CORES (NUM_CORES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .poll_req    (poll_req),
    .poll_valid  (poll_valid),
    .poll_c      (poll_c),
    .poll_z      (poll_z),
    .wait_start  (wait_start),
    .wait_busy   (wait_busy),
    .wait_done   (wait_done),
    .atn_strobe  (atn_strobe),
    .atn_targets (atn_targets),
    .set_vec     (set_vec),
    .flags_q     (flags_q)
);

// File: tb/tb_evt_flag_unit.sv
module tb_evt_flag_unit;

    localparam int CORE_ID   = 3;
    localparam int NUM_CORES = 8;
    localparam int TMO_W     = 8;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [15:0]          src_pulse = '0;
    logic                 irq_pulse = 1'b0;
    logic                 irq_debug = 1'b0;
    logic                 atn_strobe = 1'b0;
    logic [NUM_CORES-1:0] atn_targets = '0;
    logic [15:0]          clr_cmd = '0;
    logic                 poll_req = 1'b0;
    logic [3:0]           poll_id = '0;
    logic                 poll_valid, poll_c, poll_z;
    logic                 wait_start = 1'b0;
    logic [3:0]           wait_id = '0;
    logic                 wait_use_tmo = 1'b0;
    logic [TMO_W-1:0]     wait_tmo = '0;
    logic                 wait_busy, wait_done, wait_timed_out;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #4 clk = ~clk;

    evt_flag_unit #(.CORE_ID(CORE_ID), .NUM_CORES(NUM_CORES), .TMO_W(TMO_W)) dut (
        .clk(clk), .rst(rst), .src_pulse(src_pulse), .irq_pulse(irq_pulse),
        .irq_debug(irq_debug), .atn_strobe(atn_strobe), .atn_targets(atn_targets),
        .clr_cmd(clr_cmd), .poll_req(poll_req), .poll_id(poll_id),
        .poll_valid(poll_valid), .poll_c(poll_c), .poll_z(poll_z),
        .wait_start(wait_start), .wait_id(wait_id), .wait_use_tmo(wait_use_tmo),
        .wait_tmo(wait_tmo), .wait_busy(wait_busy), .wait_done(wait_done),
        .wait_timed_out(wait_timed_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic poll_chk(input int id, input int exp, input string tag);
        @(negedge clk);
        poll_req = 1'b1;
        poll_id  = id[3:0];
        @(negedge clk);
        poll_req = 1'b0;
        chk({tag, " valid"}, int'(poll_valid), 1);
        chk({tag, " C"}, int'(poll_c), exp);
        chk({tag, " Z"}, int'(poll_z), exp);
    endtask

    task automatic pulse_src(input int id);
        @(negedge clk);
        src_pulse[id] = 1'b1;
        @(negedge clk);
        src_pulse = '0;
    endtask

    // pulse_at: cycle (counted from start cycle 0) in which src_pulse[id] is driven; 0 = none
    task automatic wait_run(input int id, input bit use_t, input int tmo, input int pulse_at,
                            input int exp_cyc, input int exp_to, input string tag);
        int cyc;
        @(negedge clk);
        wait_start   = 1'b1;
        wait_id      = id[3:0];
        wait_use_tmo = use_t;
        wait_tmo     = tmo[TMO_W-1:0];
        @(negedge clk);
        wait_start = 1'b0;
        cyc = 1;
        chk({tag, " busy"}, int'(wait_busy), 1);
        while (!wait_done && cyc < 80) begin
            src_pulse = '0;
            if (cyc == pulse_at) src_pulse[id] = 1'b1;
            @(negedge clk);
            cyc++;
        end
        src_pulse = '0;
        chk({tag, " cycles"}, cyc, exp_cyc);
        chk({tag, " timeout"}, int'(wait_timed_out), exp_to);
    endtask

    task automatic t_reset;
        chk("R1 poll_valid", int'(poll_valid), 0);
        chk("R1 wait_busy", int'(wait_busy), 0);
        chk("R1 wait_done", int'(wait_done), 0);
        for (int i = 0; i < 16; i++) poll_chk(i, 0, "R1 flag");
    endtask

    task automatic t_set_poll;
        for (int i = 1; i < 16; i++) begin
            if (i == 14) continue;
            pulse_src(i);
            poll_chk(i, 1, "R2 set");
            poll_chk(i, 0, "R3 consumed");
        end
    endtask

    task automatic t_irq;
        @(negedge clk); irq_pulse = 1'b1; irq_debug = 1'b1;
        @(negedge clk); irq_pulse = 1'b0; irq_debug = 1'b0;
        poll_chk(0, 0, "R4 debug ignored");
        pulse_src(0);
        poll_chk(0, 0, "R4 src bit0 ignored");
        @(negedge clk); irq_pulse = 1'b1;
        @(negedge clk); irq_pulse = 1'b0;
        poll_chk(0, 1, "R4 irq sets");
    endtask

    task automatic t_atn;
        @(negedge clk); atn_strobe = 1'b1; atn_targets = 8'b1111_0111;
        @(negedge clk); atn_strobe = 1'b0; atn_targets = '0;
        poll_chk(14, 0, "R5 others only");
        pulse_src(14);
        poll_chk(14, 0, "R5 src bit14 ignored");
        @(negedge clk); atn_strobe = 1'b1; atn_targets = 8'b0000_1000;
        @(negedge clk); atn_strobe = 1'b0; atn_targets = '0;
        poll_chk(14, 1, "R5 self hit");
    endtask

    task automatic t_clear;
        pulse_src(1);
        @(negedge clk); clr_cmd[1] = 1'b1;
        @(negedge clk); clr_cmd = '0;
        poll_chk(1, 0, "R6 owned clear");
        pulse_src(12);
        @(negedge clk); clr_cmd[12] = 1'b1;
        @(negedge clk); clr_cmd = '0;
        poll_chk(12, 0, "R6 owned clear 12");
        pulse_src(15);
        pulse_src(13);
        @(negedge clk); irq_pulse = 1'b1;
        @(negedge clk); irq_pulse = 1'b0; clr_cmd = 16'hE001;
        @(negedge clk); clr_cmd = '0;
        poll_chk(15, 1, "R6 bit15 no effect");
        poll_chk(13, 1, "R6 bit13 no effect");
        poll_chk(0, 1, "R6 bit0 no effect");
    endtask

    task automatic t_set_wins;
        @(negedge clk); src_pulse[2] = 1'b1; clr_cmd[2] = 1'b1;
        @(negedge clk); src_pulse = '0; clr_cmd = '0;
        poll_chk(2, 1, "R7 set over clear");
        @(negedge clk); src_pulse[5] = 1'b1; poll_req = 1'b1; poll_id = 4'd5;
        @(negedge clk); src_pulse = '0; poll_req = 1'b0;
        chk("R7 poll sees old value", int'(poll_c), 0);
        poll_chk(5, 1, "R7 set over poll");
    endtask

    task automatic t_wait;
        pulse_src(9);
        wait_run(9, 1'b0, 0, 0, 2, 0, "R8 already set");
        poll_chk(9, 0, "R8 consumed");
        wait_run(10, 1'b0, 0, 25, 27, 0, "R9 no timeout");
        wait_run(11, 1'b1, 5, 0, 6, 1, "R10 expiry");
        wait_run(11, 1'b1, 0, 0, 2, 1, "R10 zero");
        wait_run(4, 1'b1, 5, 4, 6, 0, "R11 event on expiry");
        poll_chk(4, 0, "R11 consumed");
        wait_run(6, 1'b1, 5, 5, 6, 1, "R10 event too late");
        poll_chk(6, 1, "R10 flag kept");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_set_poll();
        t_irq();
        t_atn();
        t_clear();
        t_set_wins();
        t_wait();
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!ended) begin
            ended = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule